// File: doc/BRIEF.md
# Spike-Timing Learning Synapse Gate

This block models one learnable connection between a source neuron and a target neuron in a timestep-driven spiking fabric. On every step tick it samples a source spike and a target spike. It keeps a short, bounded memory of recent firing for each side. From the order in which the two sides fire, it decides whether the connection should be strengthened or weakened. The learned state is a single binary gate.

A target spike that arrives while the source memory is still live counts as a strengthening event, and the gate opens. A source spike that arrives while the target memory is still live counts as a weakening event, and the gate closes. Either event wipes both memories. While the gate is open, source spikes are passed to the target side through a two-step pipeline. All state changes happen only on clock edges where the step tick is high.

Top module: `stdp_synapse`

## Requirements
- R1: While `rst` is high and on the first clock after it, `gate`, `relay_spk`, `pot_evt` and `dep_evt` are 0, and neither side's history is armed.
- R2: A source spike on a step arms the source history for the next `win_len`+1 steps. A target spike on any of those steps raises `pot_evt` for exactly one clock after that step's edge. A target spike on a later step does not raise it.
- R3: A target spike arms the target history in the same way. A source spike while that history is armed raises `dep_evt` for one clock after that step's edge.
- R4: After a strengthening event, `gate` reads 1 from the clock following that step's edge. It stays 1 until a weakening event occurs.
- R5: A weakening event drives `gate` to 0 from the following clock. It stays 0 until the next strengthening event.
- R6: If both conditions hold on the same step, only `dep_evt` is raised and `gate` becomes 0.
- R7: Any event clears both histories. The spikes that caused it do not re-arm either history.
- R8: A source spike on step t, while `gate` is 1, makes `relay_spk` read 1 after the edge of step t+1, and only until the next step edge. With `gate` at 0, no relay occurs.
- R9: Spikes on clocks where `step` is 0 are ignored, and history counts do not advance on those clocks.
- R10: With `win_len`=0, a history is held for exactly one following step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Timestep tick; state advances only when high |
| pre_spk | input | 1 | Source-side spike for this step |
| post_spk | input | 1 | Target-side spike for this step |
| win_len | input | WIN_W (4) | History length minus one, in steps |
| relay_spk | output | 1 | Source spike relayed through the open gate |
| gate | output | 1 | Learned connection state |
| pot_evt | output | 1 | One-clock strengthening flag |
| dep_evt | output | 1 | One-clock weakening flag |

## Verification
The hardest state to reach is a same-step conflict. For it, both histories must be armed at once, yet no event may have fired and wiped them. The stimulus builds this state with a coincident source and target spike while both memories are empty; that spike pair arms both sides without triggering any event. A second coincident pair on the next step then exercises the priority rule. Window boundaries are probed by placing the partner spike exactly on the last live step and on the step after it, both for a wide window and for a zero window.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    localparam int DEF_WIN_W = 4;

    typedef struct packed {
        logic pot;
        logic dep;
    } stdp_evt_t;

    // Weakening wins when both orderings are seen in one step.
    function automatic stdp_evt_t resolve_evt(input logic pot_raw, input logic dep_raw);
        stdp_evt_t e;
        e.dep = dep_raw;
        e.pot = pot_raw & ~dep_raw;
        return e;
    endfunction

endpackage

// File: rtl/stdp_hist.sv
module stdp_hist #(
    parameter int WIN_W = stdp_pkg::DEF_WIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             spk,
    input  logic             clr,
    input  logic [WIN_W-1:0] win_len,
    output logic             armed
);
    logic             armed_q;
    logic [WIN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (step) begin
            if (clr) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (spk) begin
                armed_q <= 1'b1;
                cnt_q   <= win_len;
            end else if (armed_q) begin
                if (cnt_q == '0) armed_q <= 1'b0;
                else             cnt_q   <= cnt_q - 1'b1;
            end
        end
    end

    assign armed = armed_q;

    assert_hold_nostep_R9: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(armed));
    assert_clear_on_evt_R7: assert property (@(posedge clk) disable iff (rst)
        (step && clr) |=> !armed);

endmodule

// File: rtl/stdp_gate.sv
module stdp_gate
    import stdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    input  stdp_evt_t evt,
    output logic      gate,
    output logic      pot_evt,
    output logic      dep_evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gate    <= 1'b0;
            pot_evt <= 1'b0;
            dep_evt <= 1'b0;
        end else begin
            pot_evt <= step & evt.pot;
            dep_evt <= step & evt.dep;
            if (step) begin
                if (evt.dep)      gate <= 1'b0;
                else if (evt.pot) gate <= 1'b1;
            end
        end
    end

    assert_gate_open_R4: assert property (@(posedge clk) disable iff (rst)
        (step && evt.pot) |=> gate);
    assert_gate_close_R5: assert property (@(posedge clk) disable iff (rst)
        (step && evt.dep) |=> !gate);
    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(pot_evt && dep_evt));

endmodule

// File: rtl/stdp_relay.sv
module stdp_relay (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic pre_spk,
    input  logic gate,
    output logic relay_spk
);
    logic stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= 1'b0;
            relay_spk <= 1'b0;
        end else if (step) begin
            stage_q   <= pre_spk & gate;
            relay_spk <= stage_q;
        end
    end

    assert_relay_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(relay_spk) |-> $past(step));

endmodule

// File: rtl/stdp_synapse.sv
module stdp_synapse
    import stdp_pkg::*;
#(
    parameter int WIN_W = DEF_WIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             pre_spk,
    input  logic             post_spk,
    input  logic [WIN_W-1:0] win_len,
    output logic             relay_spk,
    output logic             gate,
    output logic             pot_evt,
    output logic             dep_evt
);
    logic      pre_armed, post_armed;
    stdp_evt_t evt;
    logic      evt_any;

    assign evt     = resolve_evt(post_spk & pre_armed, pre_spk & post_armed);
    assign evt_any = evt.pot | evt.dep;

    stdp_hist #(.WIN_W(WIN_W)) u_pre_hist (
        .clk(clk), .rst(rst), .step(step), .spk(pre_spk),
        .clr(evt_any), .win_len(win_len), .armed(pre_armed)
    );

    stdp_hist #(.WIN_W(WIN_W)) u_post_hist (
        .clk(clk), .rst(rst), .step(step), .spk(post_spk),
        .clr(evt_any), .win_len(win_len), .armed(post_armed)
    );

    stdp_gate u_gate (
        .clk(clk), .rst(rst), .step(step), .evt(evt),
        .gate(gate), .pot_evt(pot_evt), .dep_evt(dep_evt)
    );

    stdp_relay u_relay (
        .clk(clk), .rst(rst), .step(step), .pre_spk(pre_spk),
        .gate(gate), .relay_spk(relay_spk)
    );

    assert_pot_opens_R4: assert property (@(posedge clk) disable iff (rst)
        pot_evt |-> gate);
    assert_dep_closes_R5: assert property (@(posedge clk) disable iff (rst)
        dep_evt |-> !gate);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!gate && !pot_evt && !dep_evt && !relay_spk && !pre_armed && !post_armed));

endmodule

// File: tb/sim_stdp_synapse.sv
`timescale 1ns/1ps
module sim_stdp_synapse;
    localparam int WIN_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step = 1'b0, pre_spk = 1'b0, post_spk = 1'b0;
    logic [WIN_W-1:0] win_len = 4'd3;
    logic relay_spk, gate, pot_evt, dep_evt;

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stdp_synapse #(.WIN_W(WIN_W)) u0 (
        .clk(clk), .rst(rst), .step(step), .pre_spk(pre_spk), .post_spk(post_spk),
        .win_len(win_len), .relay_spk(relay_spk), .gate(gate),
        .pot_evt(pot_evt), .dep_evt(dep_evt)
    );

    // behavioural reference: counts as integers, relay as a queue
    int m_pre = -1, m_post = -1;
    int m_gate = 0, m_pf = 0, m_df = 0;
    int m_q[$] = '{0, 0};

    always @(posedge clk) begin
        if (rst) begin
            m_pre = -1; m_post = -1; m_gate = 0; m_pf = 0; m_df = 0;
            m_q = '{0, 0};
        end else begin
            m_pf = 0; m_df = 0;
            if (step) begin
                int p, d;
                d = (pre_spk && m_post >= 0) ? 1 : 0;
                p = (post_spk && m_pre >= 0 && d == 0) ? 1 : 0;
                if (p == 1 || d == 1) begin
                    m_pre = -1; m_post = -1;
                end else begin
                    m_pre  = pre_spk  ? int'(win_len) : (m_pre  >= 1 ? m_pre  - 1 : -1);
                    m_post = post_spk ? int'(win_len) : (m_post >= 1 ? m_post - 1 : -1);
                end
                m_q.push_back((pre_spk && m_gate == 1) ? 1 : 0);
                void'(m_q.pop_front());
                if (d == 1) m_gate = 0; else if (p == 1) m_gate = 1;
                m_pf = p; m_df = d;
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8", "relay_spk vs model", int'(relay_spk), m_q[0]);
            check("R4", "gate vs model", int'(gate), m_gate);
            check("R2", "pot_evt vs model", int'(pot_evt), m_pf);
            check("R3", "dep_evt vs model", int'(dep_evt), m_df);
        end
    end

    task automatic stp(input logic a, input logic b);
        step = 1'b1; pre_spk = a; post_spk = b;
        @(negedge clk);
        step = 1'b0; pre_spk = 1'b0; post_spk = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) stp(1'b0, 1'b0);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "gate", int'(gate), 0);
        check("R1", "relay", int'(relay_spk), 0);
        check("R1", "flags", int'(pot_evt | dep_evt), 0);

        // R2 target spike on the last live step of the source window
        stp(1, 0); idle(3); stp(0, 1);
        check("R2", "pot at window edge", int'(pot_evt), 1);
        check("R4", "gate opens", int'(gate), 1);
        @(negedge clk);
        check("R2", "pot is one clock", int'(pot_evt), 0);

        // R2 one step past the window
        stp(1, 0); idle(4); stp(0, 1);
        check("R2", "no pot past window", int'(pot_evt), 0);
        check("R4", "gate persists", int'(gate), 1);
        // R3/R5 weakening
        idle(1); stp(1, 0);
        check("R3", "dep inside window", int'(dep_evt), 1);
        check("R5", "gate closes", int'(gate), 0);
        // R7 histories wiped by the event
        stp(0, 1);
        check("R7", "no pot after clear", int'(pot_evt), 0);
        check("R5", "gate stays closed", int'(gate), 0);
        idle(5);

        // R8 relay with gate open
        stp(1, 0); stp(0, 1);
        check("R4", "gate reopened", int'(gate), 1);
        stp(1, 0);
        check("R8", "relay not yet", int'(relay_spk), 0);
        stp(0, 0);
        check("R8", "relay after two steps", int'(relay_spk), 1);
        stp(0, 0);
        check("R8", "relay one step only", int'(relay_spk), 0);
        idle(4);

        // R6 same-step conflict
        stp(1, 1);
        check("R6", "coincident pair no event", int'(pot_evt | dep_evt), 0);
        stp(1, 1);
        check("R6", "dep wins", int'(dep_evt), 1);
        check("R6", "no pot", int'(pot_evt), 0);
        check("R6", "gate closed", int'(gate), 0);
        idle(5);

        // R8 no relay with gate closed
        stp(1, 0); stp(0, 0); stp(0, 0);
        check("R8", "no relay gate closed", int'(relay_spk), 0);
        idle(4);

        // R9 spikes without step are ignored
        pre_spk = 1'b1;
        repeat (3) @(negedge clk);
        pre_spk = 1'b0;
        stp(0, 1);
        check("R9", "no pot from unstepped spikes", int'(pot_evt), 0);
        idle(5);

        // R9 idle clocks do not age the window
        stp(1, 0);
        repeat (10) @(negedge clk);
        idle(3); stp(0, 1);
        check("R9", "window frozen between steps", int'(pot_evt), 1);
        idle(5);

        // R10 zero-length window
        win_len = 4'd0;
        stp(1, 0); stp(0, 1);
        check("R10", "pot next step", int'(pot_evt), 1);
        stp(1, 0); stp(0, 0); stp(0, 1);
        check("R10", "expired after one step", int'(pot_evt), 0);
        idle(3);

        finish_run();
    end
endmodule